// File: doc/BRIEF.md
# Disk Bus Controller Host Register File

This block is the register file that host software sees on a disk bus controller. The host reaches sixteen byte-wide registers, picked by address bits 5 down to 2. Reads and writes at the same index can reach different registers. A 16-entry byte FIFO sits behind one index. A command register decodes an opcode and a DMA flag. The block keeps status, interrupt-reason and sequence-step registers, and it drives the interrupt request line.

Sequencing on the disk bus itself is done elsewhere. This block only starts operations on that sequencer with `op_start`. The sequencer later signals completion on `done_stb`, together with the status byte to latch.

A small state machine holds two states:
- `ST_IDLE`: no bus operation is in flight.
- `ST_BUSY`: an operation has started and its completion is awaited.

It has two transitions:
- `ST_IDLE -> ST_BUSY` on an accepted select to a present target, or on a DMA transfer command.
- `ST_BUSY -> ST_IDLE` on `done_stb`.

Top module: `dbc_regfile`

## Requirements
- R1: After reset, the status, interrupt-reason, sequence-step and byte-count registers (read indices 4, 5, 6 and 7) read 0. `irq`, `op_start` and `dma_irq_clr` are low, and the FIFO is empty.
- R2: Writing index 2 pushes the byte into a 16-entry FIFO. A push when the FIFO is full is ignored. Reading index 2 pops the oldest byte into `rdata`. A pop when the FIFO is empty is ignored, and `rdata` repeats the last popped byte. When the FIFO empties, its pointers return to slot 0.
- R3: A read of index 2 that pops a byte sets `irq` high on the same clock edge.
- R4: Index 3 reads back the last written command byte. Bit 7 of that byte drives `dma_mode`, and bits 6:0 are the opcode. Opcode 0x00 changes nothing.
- R5: Opcode 0x01 (FIFO flush) sets the interrupt reason to 0x08 and the sequence step to 0. The FIFO contents and count are left as they are.
- R6: Opcode 0x03 (bus reset) sets the interrupt reason to 0x80. It raises `irq` only when bit 6 of configuration register 8 is 0.
- R7: A read of index 5 returns the interrupt reason. It clears every status bit except bit 4 (terminal count, 0x10) and drops `irq`. It also pulses `dma_irq_clr` high for exactly one cycle.
- R8: Writes to indices 0, 1, 8 and 12–15 read back unchanged at the same index. Index 11 keeps the written value ANDed with 0x15. Indices 9 and 10 read 0.
- R9: Opcode 0x10 with bit 7 clear (transfer without DMA) does three things when the block is in `ST_IDLE`. It loads the FIFO count with min({index1,index0}, 16) and resets the FIFO pointers. It loads the low byte of the transfer count into read index 7. It raises `irq`.
- R10: Opcode 0x42 (select) takes the target number from bits 2:0 of write index 4. A target of 4 or more gives interrupt reason 0x20, sequence step 0 and `irq` high, and no `op_start`. Any other target gives a one-cycle `op_start` with `op_is_xfer` = 0 and `op_target` set to the target, and enters `ST_BUSY`.
- R11: `done_stb` in `ST_BUSY` latches `done_status` into status (index 4). It sets the interrupt reason to 0x18 and the sequence step to 4, raises `irq`, and returns to `ST_IDLE`. `done_stb` in `ST_IDLE` is ignored.
- R12: Opcode 0x10 with bit 7 set (transfer with DMA) gives a one-cycle `op_start` with `op_is_xfer` = 1 and enters `ST_BUSY`. It leaves the FIFO count and read index 7 unchanged.
- R13: In `ST_BUSY`, select and transfer commands are ignored. They cause no `op_start`, no FIFO load and no change of read index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register index, address bits [5:2] |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |
| dma_irq_clr | output | 1 | One-cycle pulse telling the DMA engine to clear its interrupt |
| dma_mode | output | 1 | DMA flag from the last command byte |
| op_start | output | 1 | One-cycle start request to the bus sequencer |
| op_is_xfer | output | 1 | 1: the started operation is a transfer; 0: it is a select |
| op_target | output | 3 | Target number of the started operation |
| done_stb | input | 1 | Completion strobe from the bus sequencer |
| done_status | input | 8 | Status byte to latch on completion |

## Verification
A wrong FIFO pointer or count shows up on the very next pop of index 2. The popped byte comes out of order, or it repeats or skips a byte. A wrong count after a non-DMA transfer shows as a pop past the loaded length that still returns new data.

A stuck `ST_BUSY` shows one command later. A following select raises no `op_start`, and a following completion changes nothing, so indices 4 and 5 keep stale codes. Every register effect is visible on `rdata` one cycle after the read strobe. Interrupt effects are visible on `irq` one cycle after the causing access.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_t;

    // register indices whose position matters to software
    localparam logic [3:0] IX_TC_LO  = 4'd0;
    localparam logic [3:0] IX_TC_HI  = 4'd1;
    localparam logic [3:0] IX_FIFO   = 4'd2;
    localparam logic [3:0] IX_CMD    = 4'd3;
    localparam logic [3:0] IX_STAT   = 4'd4;   // write view: target id
    localparam logic [3:0] IX_REASON = 4'd5;
    localparam logic [3:0] IX_STEP   = 4'd6;
    localparam logic [3:0] IX_BCNT   = 4'd7;
    localparam logic [3:0] IX_CFG    = 4'd8;
    localparam logic [3:0] IX_MASKED = 4'd11;

    // opcodes (bits 6:0 of the command byte)
    localparam logic [6:0] OP_NOP    = 7'h00;
    localparam logic [6:0] OP_FLUSH  = 7'h01;
    localparam logic [6:0] OP_BUSRST = 7'h03;
    localparam logic [6:0] OP_XFER   = 7'h10;
    localparam logic [6:0] OP_SELECT = 7'h42;

    // interrupt reason codes
    localparam logic [7:0] RSN_FLUSHED = 8'h08;
    localparam logic [7:0] RSN_DONE    = 8'h18;
    localparam logic [7:0] RSN_GONE    = 8'h20;
    localparam logic [7:0] RSN_BUSRST  = 8'h80;

    localparam logic [7:0] STEP_DONE    = 8'h04;
    localparam logic [7:0] STAT_KEEP    = 8'h10;
    localparam logic [7:0] MASK_IX11    = 8'h15;
    localparam int         CFG_RST_MASK = 6;

endpackage

// File: rtl/dbc_fifo.sv
module dbc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          pop_ok
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic          push_ok;

    assign push_ok = push && (count < CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign head    = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else if (load) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= load_cnt;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10: begin
                    wptr  <= bump(wptr);
                    count <= count + 1'b1;
                end
                2'b01: begin
                    if (count == CW'(1)) begin
                        rptr <= '0;
                        wptr <= '0;
                    end else begin
                        rptr <= bump(rptr);
                    end
                    count <= count - 1'b1;
                end
                2'b11: begin
                    wptr <= bump(wptr);
                    rptr <= bump(rptr);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dbc_seq_fsm.sv
module dbc_seq_fsm
    import dbc_pkg::*;
#(
    parameter int TGT_W     = 3,
    parameter int TGT_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sel,
    input  logic             req_xfer,
    input  logic [TGT_W-1:0] target,
    input  logic             done_stb,
    output logic             op_start,
    output logic             op_is_xfer,
    output logic [TGT_W-1:0] op_target,
    output logic             busy,
    output logic             absent_evt,
    output logic             done_evt
);
    seq_state_t st, st_nx;
    logic       go;

    always_comb begin
        st_nx      = st;
        go         = 1'b0;
        absent_evt = 1'b0;
        done_evt   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_sel) begin
                    if (32'(target) >= TGT_LIMIT) begin
                        absent_evt = 1'b1;
                    end else begin
                        go    = 1'b1;
                        st_nx = ST_BUSY;
                    end
                end else if (req_xfer) begin
                    go    = 1'b1;
                    st_nx = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (done_stb) begin
                    done_evt = 1'b1;
                    st_nx    = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start   <= 1'b0;
            op_is_xfer <= 1'b0;
            op_target  <= '0;
        end else begin
            op_start <= go;
            if (go) begin
                op_is_xfer <= !req_sel;
                op_target  <= target;
            end
        end
    end

    assign busy = (st == ST_BUSY);
endmodule

// File: rtl/dbc_regfile.sv
module dbc_regfile
    import dbc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int EXT_BASE   = 12,
    parameter int EXT_NUM    = 4,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [5:2] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       dma_irq_clr,
    output logic       dma_mode,
    output logic       op_start,
    output logic       op_is_xfer,
    output logic [2:0] op_target,
    input  logic       done_stb,
    input  logic [7:0] done_status
);
    logic [7:0] tc_lo, tc_hi, cmd_r, status, reason, step, bcnt, cfg8, cfg11, last_pop;
    logic [2:0] tgt;
    logic [7:0] ext_r [EXT_NUM];
    logic [7:0] rview;

    logic          cmd_wr, req_sel, req_ti, req_xfer, ti_local;
    logic          busy, absent_evt, done_evt;
    logic [15:0]   tc_full;
    logic [CW-1:0] load_cnt, fifo_cnt;
    logic [7:0]    fifo_head;
    logic          pop_ok;

    assign cmd_wr   = wr_en && (addr == IX_CMD);
    assign req_sel  = cmd_wr && (wdata[6:0] == OP_SELECT);
    assign req_ti   = cmd_wr && (wdata[6:0] == OP_XFER);
    assign req_xfer = req_ti && wdata[7];
    assign ti_local = req_ti && !wdata[7] && !busy;
    assign tc_full  = {tc_hi, tc_lo};
    assign load_cnt = (tc_full > 16'(FIFO_DEPTH)) ? CW'(FIFO_DEPTH) : tc_full[CW-1:0];
    assign dma_mode = cmd_r[7];

    dbc_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en && (addr == IX_FIFO)),
        .pop      (rd_en && (addr == IX_FIFO)),
        .load     (ti_local),
        .load_cnt (load_cnt),
        .din      (wdata),
        .head     (fifo_head),
        .count    (fifo_cnt),
        .pop_ok   (pop_ok)
    );

    dbc_seq_fsm #(.TGT_W(3), .TGT_LIMIT(4)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_sel    (req_sel),
        .req_xfer   (req_xfer),
        .target     (tgt),
        .done_stb   (done_stb),
        .op_start   (op_start),
        .op_is_xfer (op_is_xfer),
        .op_target  (op_target),
        .busy       (busy),
        .absent_evt (absent_evt),
        .done_evt   (done_evt)
    );

    // plain storage registers at indices 12 and up
    for (genvar gi = 0; gi < EXT_NUM; gi++) begin : g_ext
        always_ff @(posedge clk) begin
            if (!rst_n)                                   ext_r[gi] <= '0;
            else if (wr_en && (addr == 4'(EXT_BASE + gi))) ext_r[gi] <= wdata;
        end
    end

    always_comb begin
        rview = '0;
        case (addr)
            IX_TC_LO:  rview = tc_lo;
            IX_TC_HI:  rview = tc_hi;
            IX_FIFO:   rview = last_pop;
            IX_CMD:    rview = cmd_r;
            IX_STAT:   rview = status;
            IX_REASON: rview = reason;
            IX_STEP:   rview = step;
            IX_BCNT:   rview = bcnt;
            IX_CFG:    rview = cfg8;
            IX_MASKED: rview = cfg11;
            default: begin
                for (int i = 0; i < EXT_NUM; i++)
                    if (addr == 4'(EXT_BASE + i)) rview = ext_r[i];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_lo <= '0; tc_hi <= '0; cmd_r <= '0; tgt <= '0;
            status <= '0; reason <= '0; step <= '0; bcnt <= '0;
            cfg8 <= '0; cfg11 <= '0; last_pop <= '0; rdata <= '0;
            irq <= 1'b0; dma_irq_clr <= 1'b0;
        end else begin
            dma_irq_clr <= 1'b0;

            // host reads (acknowledge first, so later events win)
            if (rd_en) begin
                if (addr == IX_FIFO) begin
                    if (pop_ok) begin
                        rdata    <= fifo_head;
                        last_pop <= fifo_head;
                        irq      <= 1'b1;
                    end else begin
                        rdata <= last_pop;
                    end
                end else if (addr == IX_REASON) begin
                    rdata       <= reason;
                    status      <= status & STAT_KEEP;
                    irq         <= 1'b0;
                    dma_irq_clr <= 1'b1;
                end else begin
                    rdata <= rview;
                end
            end

            // host writes
            if (wr_en) begin
                case (addr)
                    IX_TC_LO:  tc_lo <= wdata;
                    IX_TC_HI:  tc_hi <= wdata;
                    IX_CMD:    cmd_r <= wdata;
                    IX_STAT:   tgt   <= wdata[2:0];
                    IX_CFG:    cfg8  <= wdata;
                    IX_MASKED: cfg11 <= wdata & MASK_IX11;
                    default: ;
                endcase
            end

            if (cmd_wr) begin
                case (wdata[6:0])
                    OP_FLUSH: begin
                        reason <= RSN_FLUSHED;
                        step   <= '0;
                    end
                    OP_BUSRST: begin
                        reason <= RSN_BUSRST;
                        if (!cfg8[CFG_RST_MASK]) irq <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (ti_local) begin
                bcnt <= tc_lo;
                irq  <= 1'b1;
            end

            if (absent_evt) begin
                reason <= RSN_GONE;
                step   <= '0;
                irq    <= 1'b1;
            end

            if (done_evt) begin
                status <= done_status;
                reason <= RSN_DONE;
                step   <= STEP_DONE;
                irq    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbc_regfile_chk.sv
module dbc_regfile_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          wr_en,
    input logic [5:2]    addr,
    input logic          done_stb,
    input logic          irq,
    input logic          dma_irq_clr,
    input logic          op_start,
    input logic          busy,
    input logic [CW-1:0] fifo_cnt
);
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) fifo_cnt <= CW'(DEPTH)); // R2
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'd2 && !wr_en && fifo_cnt == '0) |=> (fifo_cnt == '0)); // R2
    AST_POP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'd2 && fifo_cnt != '0) |=> irq); // R3
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'd5 && !wr_en && !done_stb) |=> !irq); // R7
    AST_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq_clr |-> $past(rd_en && addr == 4'd5)); // R7
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(!busy && wr_en && addr == 4'd3)); // R13
endmodule

bind dbc_regfile dbc_regfile_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .done_stb    (done_stb),
    .irq         (irq),
    .dma_irq_clr (dma_irq_clr),
    .op_start    (op_start),
    .busy        (busy),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/dbc_regfile_bench.sv
module dbc_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, done_stb = 1'b0;
    logic [5:2] addr = '0;
    logic [7:0] wdata = '0, done_status = '0;
    logic [7:0] rdata;
    logic       irq, dma_irq_clr, dma_mode, op_start, op_is_xfer;
    logic [2:0] op_target;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    dbc_regfile u_dbc_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .dma_irq_clr(dma_irq_clr),
        .dma_mode(dma_mode), .op_start(op_start), .op_is_xfer(op_is_xfer),
        .op_target(op_target), .done_stb(done_stb), .done_status(done_status)
    );

    // {write, index, data-or-expected}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'd0,  8'hA5}, {1'b0, 4'd0,  8'hA5},
        {1'b1, 4'd1,  8'h3C}, {1'b0, 4'd1,  8'h3C},
        {1'b1, 4'd8,  8'h07}, {1'b0, 4'd8,  8'h07},
        {1'b1, 4'd11, 8'hFF}, {1'b0, 4'd11, 8'h15},
        {1'b1, 4'd12, 8'h11}, {1'b1, 4'd13, 8'h22},
        {1'b1, 4'd14, 8'h33}, {1'b1, 4'd15, 8'h44},
        {1'b0, 4'd12, 8'h11}, {1'b0, 4'd15, 8'h44},
        {1'b0, 4'd9,  8'h00}, {1'b0, 4'd10, 8'h00},
        {1'b1, 4'd3,  8'h00}, {1'b0, 4'd3,  8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] ix, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = ix; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ix, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = ix;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] ix, input logic [7:0] exp);
        logic [7:0] v;
        rd(ix, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_done(input logic [7:0] st);
        @(negedge clk); done_stb = 1'b1; done_status = st;
        @(negedge clk); done_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 op_start", {7'd0, op_start}, 8'h00);
        rdchk("R1 status", 4'd4, 8'h00);
        rdchk("R1 step", 4'd6, 8'h00);
        rdchk("R1 bcnt", 4'd7, 8'h00);
        rdchk("R1 reason", 4'd5, 8'h00);
        rdchk("R1 empty pop", 4'd2, 8'h00);
        chk("R1 empty pop no irq", {7'd0, irq}, 8'h00);

        // R8 / R4 vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) wr(VEC[i][11:8], VEC[i][7:0]);
            else rdchk("R8 R4 table", VEC[i][11:8], VEC[i][7:0]);
        end

        // R2 / R3 basic FIFO order
        wr(4'd2, 8'h01); wr(4'd2, 8'h02); wr(4'd2, 8'h03);
        rdchk("R2 pop0", 4'd2, 8'h01);
        chk("R3 pop irq", {7'd0, irq}, 8'h01);
        rdchk("R2 pop1", 4'd2, 8'h02);
        rdchk("R2 pop2", 4'd2, 8'h03);
        rd(4'd5, v);
        chk("R7 clr pulse", {7'd0, dma_irq_clr}, 8'h01);
        chk("R7 irq dropped", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R7 clr one cycle", {7'd0, dma_irq_clr}, 8'h00);
        rdchk("R2 pop empty repeats", 4'd2, 8'h03);
        chk("R3 empty pop no irq", {7'd0, irq}, 8'h00);

        // R2 saturation: 17 pushes, only 16 kept
        for (int i = 0; i < 17; i++) wr(4'd2, 8'(8'h20 + i));
        for (int i = 0; i < 16; i++) rdchk("R2 full order", 4'd2, 8'(8'h20 + i));
        rdchk("R2 push when full dropped", 4'd2, 8'h2F);
        rd(4'd5, v);

        // R9 non-DMA transfer, count 2
        wr(4'd0, 8'h02); wr(4'd1, 8'h00);
        wr(4'd3, 8'h10);
        chk("R9 irq", {7'd0, irq}, 8'h01);
        chk("R4 dma_mode low", {7'd0, dma_mode}, 8'h00);
        rdchk("R9 bcnt", 4'd7, 8'h02);
        rdchk("R9 pop slot0", 4'd2, 8'h20);
        rdchk("R9 pop slot1", 4'd2, 8'h21);
        rdchk("R9 count exhausted", 4'd2, 8'h21);
        // R9 count clamps at 16
        wr(4'd0, 8'h20); wr(4'd1, 8'h01);
        wr(4'd3, 8'h10);
        rdchk("R9 bcnt low byte", 4'd7, 8'h20);
        for (int i = 0; i < 16; i++) rdchk("R9 clamped pops", 4'd2, 8'(8'h20 + i));
        rdchk("R9 clamp at 16", 4'd2, 8'h2F);
        rd(4'd5, v);

        // R5 flush keeps FIFO
        wr(4'd2, 8'h5A);
        wr(4'd3, 8'h01);
        rdchk("R5 reason", 4'd5, 8'h08);
        rdchk("R5 step", 4'd6, 8'h00);
        rdchk("R5 fifo kept", 4'd2, 8'h5A);
        rd(4'd5, v);

        // R10 select, present target
        wr(4'd4, 8'hFA);  // bits 2:0 = 2
        wr(4'd3, 8'h42);
        chk("R10 op_start", {7'd0, op_start}, 8'h01);
        chk("R10 op_target", {5'd0, op_target}, 8'h02);
        chk("R10 op_is_xfer", {7'd0, op_is_xfer}, 8'h00);
        @(negedge clk);
        chk("R10 one-cycle start", {7'd0, op_start}, 8'h00);
        // R13 commands in busy ignored
        wr(4'd3, 8'h10);
        chk("R13 no load irq", {7'd0, irq}, 8'h00);
        rdchk("R13 bcnt unchanged", 4'd7, 8'h20);
        wr(4'd3, 8'h42);
        chk("R13 no start", {7'd0, op_start}, 8'h00);
        // R11 completion
        pulse_done(8'h13);
        chk("R11 irq", {7'd0, irq}, 8'h01);
        rdchk("R11 status", 4'd4, 8'h13);
        rdchk("R11 reason", 4'd5, 8'h18);
        rdchk("R7 status keeps tc", 4'd4, 8'h10);
        rdchk("R11 step", 4'd6, 8'h04);
        // R11 done ignored in idle
        wr(4'd3, 8'h01);
        pulse_done(8'hEE);
        chk("R11 idle no irq", {7'd0, irq}, 8'h00);
        rdchk("R11 idle reason", 4'd5, 8'h08);
        rdchk("R11 idle status", 4'd4, 8'h10);

        // R12 DMA transfer
        wr(4'd3, 8'h90);
        chk("R12 op_start", {7'd0, op_start}, 8'h01);
        chk("R12 op_is_xfer", {7'd0, op_is_xfer}, 8'h01);
        chk("R4 dma_mode high", {7'd0, dma_mode}, 8'h01);
        rdchk("R12 bcnt unchanged", 4'd7, 8'h20);
        rdchk("R4 cmd readback", 4'd3, 8'h90);
        pulse_done(8'h00);
        rd(4'd5, v);

        // R6 bus reset, mask clear then set
        wr(4'd8, 8'h00);
        wr(4'd3, 8'h03);
        chk("R6 irq unmasked", {7'd0, irq}, 8'h01);
        rdchk("R6 reason", 4'd5, 8'h80);
        wr(4'd8, 8'h40);
        wr(4'd3, 8'h03);
        chk("R6 irq masked", {7'd0, irq}, 8'h00);
        rdchk("R6 reason masked", 4'd5, 8'h80);

        // R10 absent target
        wr(4'd4, 8'h05);
        wr(4'd3, 8'hC2);
        chk("R10 absent no start", {7'd0, op_start}, 8'h00);
        chk("R10 absent irq", {7'd0, irq}, 8'h01);
        rdchk("R10 absent reason", 4'd5, 8'h20);
        rdchk("R10 absent step", 4'd6, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule